// File: doc/BRIEF.md
# Two-Bit-Per-Step Successive Approximation Controller

This block sequences a successive-approximation conversion in which every approximation cycle resolves two result bits instead of one. The lone comparator of a classic approximation loop is replaced by a tiny flash stage: three level comparators and one over-range comparator look at the remaining interval at once, and the controller turns their thermometer word into a two-bit decision. The decision is placed into the approximation register, working from the top pair of bits down to the bottom pair.

The controller presents the current trial code and the width of one quarter of the open interval (`span_o`) to an external DAC and comparator bank. Comparator `k` (k = 0, 1, 2) reports whether the held input is at or above `dac_code_o + (k+1)*span_o`, and the over-range comparator reports whether the input is at or above `dac_code_o + 4*span_o`. A pulse on `start_i` launches a conversion. `busy_o` and `hold_o` stay high while it runs. The result appears on `result_o` together with a one-cycle `valid_o` strobe, a flag for an over-range input and a flag for a corrected comparator word.

Top module: `hybrid_sar2`

## Requirements
- R1: While reset is active, and after it is released, `busy_o`, `hold_o`, `valid_o`, `range_o`, `therm_err_o` and `result_o` are all zero.
- R2: A `start_i` sampled high while idle begins a conversion. `busy_o` is then high for exactly RES_W/2 + 1 cycles: one load cycle followed by RES_W/2 decision cycles.
- R3: The approximation register is cleared when a conversion begins, so `dac_code_o` is zero during the load cycle.
- R4: Pairs are resolved from the most significant end. In decision cycle k (counting from 0), `span_o` equals 2^(RES_W-2-2k), and `dac_code_o` holds the pairs already decided above that position, with zeros below.
- R5: A monotonic thermometer word (bit 0 set first, bit 2 set last) decodes to a pair equal to its count of ones. For any input from 0 to 2^RES_W - 1, the final result equals the input code.
- R6: A set over-range comparator decodes the pair as binary 11. `range_o` is raised with the result when any step of that conversion saw it set, so inputs at or above full scale give an all-ones result with `range_o` = 1.
- R7: A thermometer word that is not monotonic is repaired by filling every position below its highest set bit. The pair is then one plus that bit index, and `therm_err_o` = 1 is reported with that conversion's result. A clean conversion clears the flag.
- R8: `result_o`, `range_o`, `therm_err_o` and `valid_o` update on the same edge, in the cycle after the last decision. In that same cycle `busy_o` falls. `valid_o` lasts one cycle, and the result holds until the next conversion completes.
- R9: `start_i` has no effect while a conversion is running: the running conversion keeps its timing and result, and no second conversion follows.
- R10: `hold_o` is high in every cycle in which `busy_o` is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request for a new conversion |
| thermo_i | input | 3 | Flash comparator word, bit k set when input >= trial + (k+1)*span |
| ovr_i | input | 1 | Over-range comparator, set when input >= trial + 4*span |
| busy_o | output | 1 | Conversion in progress |
| hold_o | output | 1 | Sample-and-hold request, high for the whole conversion |
| dac_code_o | output | RES_W | Trial code for the DAC |
| span_o | output | RES_W | Quarter-interval weight for the flash thresholds |
| result_o | output | RES_W | Last completed conversion result |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| range_o | output | 1 | Over-range comparator fired during the last conversion |
| therm_err_o | output | 1 | A non-monotonic comparator word was corrected in the last conversion |

## Verification
The bench sweeps every input code plus a band above full scale through a behavioural comparator bank. At each decision cycle it checks the trial code and span, so a design that resolved pairs in the wrong order, or shifted the span by one position, would show a mismatch long before the final result. Inputs at and above full scale target the over-range path. A decoder that ignored the fourth comparator would produce zero instead of all ones there. Forced, bubbled thermometer words at the top step check the repair rule and the error flag: a design that counted ones, or kept the lowest run, would land on a different top pair. Starts raised during a conversion and the cycle after the strobe reveal a controller that restarts, or that lets busy and valid drift apart.

// File: rtl/sar2_pkg.sv
package sar2_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_STEP = 2'd2
  } sar_state_e;

  typedef struct packed {
    logic [1:0] pair;
    logic       fixed;
    logic       over;
  } pair_dec_t;

endpackage

// File: rtl/sar2_rst_sync.sv
module sar2_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sar2_flash_decoder.sv
module sar2_flash_decoder
  import sar2_pkg::*;
#(
  parameter int LEVELS = 3
) (
  input  logic [LEVELS-1:0] thermo_i,
  input  logic              ovr_i,
  output pair_dec_t         dec_o
);

  logic [LEVELS-1:0] filled;
  logic [LEVELS:0]   hot;

  // bubble repair: a position counts as set when it or anything above it is set
  always_comb begin
    for (int i = 0; i < LEVELS; i++) begin
      filled[i] = |(thermo_i >> i);
    end
  end

  // adjacent-pair AND stage, the top level is gated by the over-range comparator
  generate
    for (genvar g = 0; g <= LEVELS; g++) begin : g_hot
      if (g == 0) begin : g_lo
        assign hot[g] = ~filled[0];
      end else if (g == LEVELS) begin : g_hi
        assign hot[g] = filled[LEVELS-1] & ~ovr_i;
      end else begin : g_mid
        assign hot[g] = filled[g-1] & ~filled[g];
      end
    end
  endgenerate

  // OR stage to binary; over-range joins both columns
  always_comb begin
    dec_o.pair[1] = hot[2] | hot[3] | ovr_i;
    dec_o.pair[0] = hot[1] | hot[3] | ovr_i;
    dec_o.fixed   = (filled != thermo_i);
    dec_o.over    = ovr_i;
  end

endmodule

// File: rtl/sar2_ctrl.sv
module sar2_ctrl
  import sar2_pkg::*;
#(
  parameter int STEPS = 4,
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          busy_o,
  output logic          clear_o,
  output logic          step_en_o,
  output logic          done_o,
  output logic [CW-1:0] step_o
);

  sar_state_e    state_q, state_d;
  logic [CW-1:0] step_q, step_d;
  logic          last_step;

  assign last_step = (step_q == CW'(STEPS - 1));

  always_comb begin
    state_d   = state_q;
    step_d    = step_q;
    clear_o   = 1'b0;
    step_en_o = 1'b0;
    done_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          clear_o = 1'b1;
          step_d  = '0;
          state_d = ST_LOAD;
        end
      end
      ST_LOAD: begin
        state_d = ST_STEP;
      end
      ST_STEP: begin
        step_en_o = 1'b1;
        if (last_step) begin
          done_o  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          step_d = step_q + CW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign step_o = step_q;

  // R2
  load_then_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD) |=> (state_q == ST_STEP && step_q == '0));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STEP && !last_step) |=> (state_q == ST_STEP && step_q == $past(step_q) + CW'(1)));

endmodule

// File: rtl/hybrid_sar2.sv
module hybrid_sar2
  import sar2_pkg::*;
#(
  parameter int RES_W = 8,
  localparam int STEPS = RES_W / 2,
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1,
  localparam int PW = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       thermo_i,
  input  logic             ovr_i,
  output logic             busy_o,
  output logic             hold_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic [RES_W-1:0] span_o,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o,
  output logic             range_o,
  output logic             therm_err_o
);

  logic          rst_sync_n;
  logic          clear, step_en, done;
  logic [CW-1:0] step;
  pair_dec_t     dec;
  logic [PW-1:0] pos;
  logic [RES_W-1:0] pair_shift, merged;

  logic [RES_W-1:0] sar_q, sar_d;
  logic [RES_W-1:0] res_q, res_d;
  logic             valid_q, valid_d;
  logic             err_acc_q, err_acc_d, rng_acc_q, rng_acc_d;
  logic             err_q, err_d, rng_q, rng_d;
  logic             sar_en, acc_en, res_en;

  sar2_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sar2_ctrl #(.STEPS(STEPS)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .clear_o   (clear),
    .step_en_o (step_en),
    .done_o    (done),
    .step_o    (step)
  );

  sar2_flash_decoder #(.LEVELS(3)) i_dec (
    .thermo_i (thermo_i),
    .ovr_i    (ovr_i),
    .dec_o    (dec)
  );

  // bit position of the low bit of the pair under decision
  assign pos        = PW'(RES_W - 2 - 2 * int'(step));
  assign span_o     = {{(RES_W-1){1'b0}}, 1'b1} << pos;
  assign pair_shift = {{(RES_W-2){1'b0}}, dec.pair} << pos;
  assign merged     = sar_q | pair_shift;

  // clock enables
  assign sar_en = clear | step_en;
  assign acc_en = clear | step_en;
  assign res_en = done;

  always_comb begin
    sar_d     = clear ? '0 : merged;
    err_acc_d = clear ? 1'b0 : (err_acc_q | dec.fixed);
    rng_acc_d = clear ? 1'b0 : (rng_acc_q | dec.over);
    res_d     = merged;
    err_d     = err_acc_q | dec.fixed;
    rng_d     = rng_acc_q | dec.over;
    valid_d   = done;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sar_q     <= '0;
      err_acc_q <= 1'b0;
      rng_acc_q <= 1'b0;
      res_q     <= '0;
      err_q     <= 1'b0;
      rng_q     <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      if (sar_en) sar_q <= sar_d;
      if (acc_en) begin
        err_acc_q <= err_acc_d;
        rng_acc_q <= rng_acc_d;
      end
      if (res_en) begin
        res_q <= res_d;
        err_q <= err_d;
        rng_q <= rng_d;
      end
      valid_q <= valid_d;
    end
  end

  assign hold_o      = busy_o;
  assign dac_code_o  = sar_q;
  assign result_o    = res_q;
  assign valid_o     = valid_q;
  assign range_o     = rng_q;
  assign therm_err_o = err_q;

  // R3
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy_o) |-> (dac_code_o == '0));

  // R4
  span_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_o |-> $onehot(span_o));

  // R4
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_o |-> ((dac_code_o & (span_o - RES_W'(1))) == '0));

  // R8
  busy_valid_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(busy_o) |-> valid_o);

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_o |=> !valid_o);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !valid_o |-> $stable(result_o));

  // R6
  over_pair_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_en && ovr_i) |=> (busy_o ? ((dac_code_o & ($past(span_o) * RES_W'(3))) == ($past(span_o) * RES_W'(3))) : 1'b1));

  // R10
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hold_o == busy_o);

endmodule

// File: tb/test_hybrid_sar2.sv
module test_hybrid_sar2;

  localparam int CLK_PERIOD = 10;
  localparam int RES_W = 8;
  localparam int STEPS = RES_W / 2;
  localparam int FULL = 1 << RES_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [2:0]       thermo;
  logic             ovr;
  logic             busy, hold, valid, rng, terr;
  logic [RES_W-1:0] dac, span, result;

  int   vin = 0;
  logic force_en = 1'b0;
  logic [2:0] force_pat = 3'b000;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hybrid_sar2 #(.RES_W(RES_W)) i_hybrid_sar2 (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .thermo_i    (thermo),
    .ovr_i       (ovr),
    .busy_o      (busy),
    .hold_o      (hold),
    .dac_code_o  (dac),
    .span_o      (span),
    .result_o    (result),
    .valid_o     (valid),
    .range_o     (rng),
    .therm_err_o (terr)
  );

  // behavioural DAC plus flash comparators; optional forced word on the top step
  always_comb begin
    int base, sp;
    base = int'(dac);
    sp   = int'(span);
    for (int k = 0; k < 3; k++) thermo[k] = (vin >= base + (k + 1) * sp);
    ovr = (vin >= base + 4 * sp);
    if (force_en && busy && sp == (FULL >> 2)) begin
      thermo = force_pat;
      ovr    = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one conversion; chk_dac enables per-step trial-code checks, poke drives start mid-run
  task automatic convert(input int v, input int exp_res, input bit exp_rng, input bit exp_err,
                         input bit chk_dac, input bit poke);
    @(negedge clk);
    vin = v;
    start = 1'b1;
    @(negedge clk);
    start = poke;
    check(busy == 1'b1, "R2 busy in load", int'(busy), 1);
    check(hold == 1'b1, "R10 hold in load", int'(hold), 1);
    check(dac == '0, "R3 cleared trial code", int'(dac), 0);
    for (int i = 0; i < STEPS; i++) begin
      int sh;
      @(negedge clk);
      start = poke;
      sh = RES_W - 2 * i;
      check(busy == 1'b1 && hold == 1'b1, "R2 R10 busy and hold in step", int'(busy), 1);
      check(valid == 1'b0, "R8 no early valid", int'(valid), 0);
      check(int'(span) == (1 << (sh - 2)), "R4 span weight", int'(span), 1 << (sh - 2));
      if (chk_dac)
        check(int'(dac) == ((exp_res >> sh) << sh), "R4 trial code msb first",
              int'(dac), (exp_res >> sh) << sh);
    end
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b0 && hold == 1'b0, "R2 R10 busy falls", int'(busy), 0);
    check(valid == 1'b1, "R8 valid with result", int'(valid), 1);
    check(int'(result) == exp_res, "R5 result", int'(result), exp_res);
    check(rng == exp_rng, "R6 range flag", int'(rng), int'(exp_rng));
    check(terr == exp_err, "R7 thermometer flag", int'(terr), int'(exp_err));
    @(negedge clk);
    check(valid == 1'b0, "R8 valid one cycle", int'(valid), 1'b0);
    check(busy == 1'b0, "R9 no restart after mid-run start", int'(busy), 0);
    check(int'(result) == exp_res, "R8 result holds", int'(result), exp_res);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(busy == 1'b0 && hold == 1'b0 && valid == 1'b0, "R1 idle in reset", int'(busy), 0);
    check(result == '0 && rng == 1'b0 && terr == 1'b0, "R1 result cleared in reset", int'(result), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && valid == 1'b0 && result == '0, "R1 idle after reset", int'(busy), 0);

    // R5 R6: every code plus a band above full scale
    for (int v = 0; v < FULL + 20; v++) begin
      int e;
      e = (v < FULL) ? v : FULL - 1;
      convert(v, e, v >= FULL, 1'b0, 1'b1, (v % 7) == 3);
    end

    // R7: bubbled words on the top step
    force_en = 1'b1;
    force_pat = 3'b101; convert(200, 200, 1'b0, 1'b1, 1'b0, 1'b0);
    force_pat = 3'b010; convert(100, 128, 1'b0, 1'b1, 1'b0, 1'b0);
    force_pat = 3'b100; convert(50, 192, 1'b0, 1'b1, 1'b0, 1'b0);
    force_pat = 3'b011; convert(50, 128, 1'b0, 1'b0, 1'b0, 1'b1);
    force_pat = 3'b110; convert(10, 192, 1'b0, 1'b1, 1'b0, 1'b0);
    force_en = 1'b0;
    // R7: clean conversion clears the flag
    convert(77, 77, 1'b0, 1'b0, 1'b1, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule